// File: doc/BRIEF.md
# Set-Associative LRU Cache Tag Model

This block decides whether each memory reference hits or misses in a set-associative cache. It stores only tags and keeps the lines of every set in strict least-recently-used order. A requester presents a byte address and an access length in bytes with a one-cycle valid strobe. The block then works through one or two lookup phases and pulses `done` together with a single hit/miss verdict. A saturating 64-bit miss counter can be read at any time and cleared through its own input.

Capacity, associativity and line length are parameters, and each is a power of two. The set index comes from the address bits just above the line offset, with no hashing. The tag is everything above the index. Each set is kept as an ordered row. Its front slot is the most recent line, and tags physically slide one slot toward the back as newer lines are touched. Every miss allocates, whether the reference is a read or a write.

A reference may cross into the following line. In that case both sets are looked up and updated, the first set before the second, and the reference still yields one combined result. A reference whose last byte lands in any set other than its own or the next one is rejected with an error and changes no state.

Top module: `lru_tagcache`

## Requirements
- R1: The number of sets is CACHE_BYTES / LINE_BYTES / WAYS. The set index is address bits [log2(LINE_BYTES) +: log2(sets)], and the tag is the address shifted right by log2(LINE_BYTES)+log2(sets). With the defaults these are bits [7:4] and [31:8].
- R2: A hit on slot i moves that tag to slot 0, and slots 0..i-1 each move back by one place. Slot 0 always holds the most recently referenced tag.
- R3: A miss shifts every slot of the set back by one place, drops the tag in the last slot, and writes the new tag into slot 0.
- R4: If the last byte (address + size - 1) falls in set (first set + 1) mod sets, both sets are looked up and updated with the start address's tag, first set first. `hit` is 1 only if both lookups hit.
- R5: Each reference adds at most one to `miss_count`. A two-line reference adds exactly one when either line misses or both do, and a single-line reference adds one on a miss.
- R6: If the last byte falls in any set other than the first set or the next set, `err` is 1 in the `done` cycle and `hit` is 0. No tag moves and the counter does not change.
- R7: Reset (synchronous, active high) clears every tag to zero, and there are no valid bits, so a tag of zero hits right after reset. Reset also clears the counter and drives `busy`, `done`, `hit` and `err` to 0.
- R8: A request is accepted when `req_valid` is 1 while `busy` is 0. `busy` is 1 from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse 2 cycles after the accepting edge for one line or an error, and 3 cycles after it for two lines. `req_valid` while `busy` is ignored.
- R9: `miss_count` holds at all ones once it gets there. When `miss_clr` is 1 at a clock edge, the count becomes 0, and the clear wins over an increment at the same edge.
- R10: With WAYS = 1 the block is direct-mapped: each miss overwrites the only tag of its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Access length in bytes, at least 1 |
| miss_clr | input | 1 | Clears the miss counter |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Reference hit, valid with done |
| err | output | 1 | Reference spanned an illegal set range, valid with done |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
The assertions assume that `req_size` is never zero and that an address plus its size fits in the address width without wrapping. The random stimulus draws sizes from 1 up to 40 bytes and keeps addresses well below the top of the address space, so short and line-crossing references occur and so do illegal spans. The counter properties assume the clear input is a level sampled at the edge. The bench asserts the clear on its own and also in the same cycle as a miss result.

// File: rtl/lru_tagcache_pkg.sv
package lru_tagcache_pkg;

    // How the bytes of one reference spread across sets.
    typedef enum logic [1:0] {
        SPAN_ONE = 2'd0,
        SPAN_TWO = 2'd1,
        SPAN_BAD = 2'd2
    } span_e;

    // Request sequencing phases.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;

    // Verdict carried into the done cycle.
    typedef struct packed {
        logic hit;
        logic err;
    } verdict_t;

    function automatic span_e classify_span(input logic same_set, input logic next_set);
        if (same_set)      return SPAN_ONE;
        else if (next_set) return SPAN_TWO;
        else               return SPAN_BAD;
    endfunction

endpackage

// File: rtl/lru_addr_split.sv
module lru_addr_split
    import lru_tagcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 6,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  second_idx,
    output logic [TAG_W-1:0]  tag,
    output span_e             span
);
    logic [ADDR_W-1:0] last_byte;
    logic [IDX_W-1:0]  follow_idx;

    always_comb begin
        // Plain bit selection: no hashing of the index (R1).
        last_byte  = addr + ADDR_W'(size) - ADDR_W'(1);
        first_idx  = IDX_W'(addr >> OFF_W);
        second_idx = IDX_W'(last_byte >> OFF_W);
        tag        = TAG_W'(addr >> (OFF_W + IDX_W));
        follow_idx = first_idx + IDX_W'(1);   // wraps modulo the set count
        span       = classify_span(first_idx == second_idx, follow_idx == second_idx);
    end

endmodule

// File: rtl/lru_set_array.sv
module lru_set_array #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    parameter int IDX_W = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag,
    input  logic             upd,
    output logic             hit
);
    logic [TAG_W-1:0] slots   [SETS][WAYS];
    logic [TAG_W-1:0] row     [WAYS];
    logic [TAG_W-1:0] nxt_row [WAYS];
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] hit_pos;
    logic [WAY_W-1:0] cut;

    genvar gw;
    generate
        for (gw = 0; gw < WAYS; gw++) begin : g_way
            assign row[gw]   = slots[idx][gw];
            assign match[gw] = (row[gw] == tag);
        end
    endgenerate

    // Lowest matching slot wins (duplicates exist only as reset zeros).
    always_comb begin
        hit_pos = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_pos = WAY_W'(w);
        end
        hit = |match;
        cut = hit ? hit_pos : WAY_W'(WAYS - 1);
    end

    // Shift slots 0..cut-1 back one place, new or hit tag to the front.
    always_comb begin
        nxt_row[0] = tag;
        for (int j = 1; j < WAYS; j++) begin
            nxt_row[j] = (j <= int'(cut)) ? row[j-1] : row[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    slots[s][w] <= '0;
                end
            end
        end else if (upd) begin
            for (int w = 0; w < WAYS; w++) begin
                slots[idx][w] <= nxt_row[w];
            end
        end
    end

    // R2: after an update the looked-up tag sits in the front slot.
    assert_mru_front_R2: assert property (@(posedge clk) disable iff (rst)
        upd |=> (slots[$past(idx)][0] == $past(tag)));

    // R3: a missing update keeps the old front tag in slot 1 (when WAYS > 1).
    generate
        if (WAYS > 1) begin : g_chk_shift
            assert_miss_shift_R3: assert property (@(posedge clk) disable iff (rst)
                (upd && !hit) |=> (slots[$past(idx)][1] == $past(row[0])));
        end
    endgenerate

endmodule

// File: rtl/lru_miss_counter.sv
module lru_miss_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + CNT_W'(1);
        end
    end

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr && count == TOP) |=> (count == TOP));

    assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && inc && count != TOP) |=> (count == $past(count) + CNT_W'(1)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(count));

endmodule

// File: rtl/lru_tagcache.sv
module lru_tagcache
    import lru_tagcache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 6,
    parameter int CACHE_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 16,
    parameter int CNT_W       = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              miss_clr,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic              err,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        logic [IDX_W-1:0] first_idx;
        logic [IDX_W-1:0] second_idx;
        logic [TAG_W-1:0] tag;
        span_e            span;
    } ref_t;

    ref_t     dec, cur;
    phase_e   phase;
    verdict_t verdict;
    logic     first_missed;
    logic     accept;
    logic     look_upd;
    logic     look_hit;
    logic     count_inc;
    logic [IDX_W-1:0] look_idx;

    lru_addr_split #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_split (
        .addr      (req_addr),
        .size      (req_size),
        .first_idx (dec.first_idx),
        .second_idx(dec.second_idx),
        .tag       (dec.tag),
        .span      (dec.span)
    );

    lru_set_array #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)
    ) u_array (
        .clk(clk),
        .rst(rst),
        .idx(look_idx),
        .tag(cur.tag),
        .upd(look_upd),
        .hit(look_hit)
    );

    lru_miss_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst  (rst),
        .inc  (count_inc),
        .clr  (miss_clr),
        .count(miss_count)
    );

    always_comb begin
        accept    = (phase == PH_IDLE) && req_valid;
        look_idx  = (phase == PH_SECOND) ? cur.second_idx : cur.first_idx;
        look_upd  = ((phase == PH_FIRST) && (cur.span != SPAN_BAD)) || (phase == PH_SECOND);
        count_inc = ((phase == PH_FIRST) && (cur.span == SPAN_ONE) && !look_hit)
                 || ((phase == PH_SECOND) && (first_missed || !look_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_IDLE;
            cur          <= '0;
            verdict      <= '0;
            first_missed <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        cur     <= dec;
                        verdict <= '0;
                        phase   <= PH_FIRST;
                    end
                end
                PH_FIRST: begin
                    first_missed <= !look_hit;
                    unique case (cur.span)
                        SPAN_ONE: begin
                            verdict <= '{hit: look_hit, err: 1'b0};
                            phase   <= PH_DONE;
                        end
                        SPAN_TWO: phase <= PH_SECOND;
                        default: begin
                            verdict <= '{hit: 1'b0, err: 1'b1};
                            phase   <= PH_DONE;
                        end
                    endcase
                end
                PH_SECOND: begin
                    verdict <= '{hit: !first_missed && look_hit, err: 1'b0};
                    phase   <= PH_DONE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_DONE);
    assign hit  = done && verdict.hit;
    assign err  = done && verdict.err;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> (busy && !done));

    assert_err_no_hit_R6: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !hit));

    assert_err_no_count_R6: assert property (@(posedge clk) disable iff (rst)
        (done && err && !$past(miss_clr)) |-> $stable(miss_count));

    assert_err_no_update_R6: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_FIRST) && (cur.span == SPAN_BAD)) |-> !look_upd);

    assert_two_line_verdict_R4: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_SECOND) && first_missed) |=> (done && !hit));

endmodule

// File: tb/lru_tagcache_tb.sv
module lru_tagcache_tb;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 6;
    localparam int M_WAYS = 4;
    localparam int M_SETS = 16;           // 1024 / 16 / 4
    localparam int CNT_W  = 64;
    localparam int S_CNT  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;                // 50 MHz

    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr  = '0;
    logic [SIZE_W-1:0] req_size  = 6'd1;
    logic              miss_clr  = 1'b0;
    logic              busy, done, hit, err;
    logic [CNT_W-1:0]  miss_count;

    logic              s_valid = 1'b0;
    logic [ADDR_W-1:0] s_addr  = '0;
    logic [SIZE_W-1:0] s_size  = 6'd1;
    logic              s_clr   = 1'b0;
    logic              s_busy, s_done, s_hit, s_err;
    logic [S_CNT-1:0]  s_count;

    lru_tagcache u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .miss_clr(miss_clr), .busy(busy), .done(done),
        .hit(hit), .err(err), .miss_count(miss_count)
    );

    lru_tagcache #(.WAYS(1), .CNT_W(S_CNT)) u_sat (
        .clk(clk), .rst(rst), .req_valid(s_valid), .req_addr(s_addr),
        .req_size(s_size), .miss_clr(s_clr), .busy(s_busy), .done(s_done),
        .hit(s_hit), .err(s_err), .miss_count(s_count)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur_req = "R7";

    // Behavioural reference: one queue of tags per set, front = most recent.
    int unsigned mq[M_SETS][$];
    bit          m_busy, m_done, m_hit, m_err, m_miss;
    int          m_left;
    longint unsigned m_cnt;

    function automatic bit ref_touch(int set, int unsigned tag);
        for (int i = 0; i < mq[set].size(); i++) begin
            if (mq[set][i] == tag) begin
                mq[set].delete(i);
                mq[set].push_front(tag);
                return 1'b1;
            end
        end
        mq[set].push_front(tag);
        if (mq[set].size() > M_WAYS) void'(mq[set].pop_back());
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < M_SETS; s++) begin
            mq[s].delete();
            for (int w = 0; w < M_WAYS; w++) mq[s].push_back(0);
        end
        m_busy = 0; m_done = 0; m_hit = 0; m_err = 0; m_miss = 0; m_left = 0; m_cnt = 0;
    endtask

    task automatic model_step();
        bit fin = 0;
        if (rst) begin
            model_reset();
            return;
        end
        if (m_busy) begin
            if (m_done) begin
                m_busy = 0; m_done = 0;
            end else begin
                m_left--;
                if (m_left == 0) begin m_done = 1; fin = 1; end
            end
        end else if (req_valid) begin
            int unsigned a, e, tag;
            int s1, s2;
            bit h1, h2;
            a   = req_addr;
            e   = a + int'(req_size) - 1;
            s1  = (a >> 4) & 15;
            s2  = (e >> 4) & 15;
            tag = a >> 8;
            m_busy = 1; m_done = 0; m_err = 0;
            if (s1 == s2) begin
                h1 = ref_touch(s1, tag);
                m_hit = h1; m_miss = !h1; m_left = 1;
            end else if (s2 == ((s1 + 1) & 15)) begin
                h1 = ref_touch(s1, tag);
                h2 = ref_touch(s2, tag);
                m_hit = h1 && h2; m_miss = !(h1 && h2); m_left = 2;
            end else begin
                m_hit = 0; m_miss = 0; m_err = 1; m_left = 1;
            end
        end
        if (fin && m_miss && m_cnt != 64'hFFFF_FFFF_FFFF_FFFF) m_cnt++;
        if (miss_clr) m_cnt = 0;
    endtask

    task automatic check(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        logic [3:0] act, exp;
        @(negedge clk);
        model_step();
        act = {busy, done, hit, err};
        exp = {m_busy, m_done, m_done & m_hit, m_done & m_err};
        check(act === exp, cur_req, "busy/done/hit/err", act, exp);
        check(miss_count === m_cnt, cur_req, "miss_count", miss_count, m_cnt);
    endtask

    task automatic send(int unsigned a, int s);
        req_valid = 1'b1; req_addr = a; req_size = SIZE_W'(s);
        tick();
        req_valid = 1'b0;
        while (m_busy) tick();
    endtask

    task automatic s_access(int unsigned a, output bit h);
        h = 0;
        s_valid = 1'b1; s_addr = a; s_size = 6'd4;
        tick();
        s_valid = 1'b0;
        for (int k = 0; k < 6 && !s_done; k++) tick();
        h = s_hit;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit sh;
        model_reset();
        cur_req = "R7";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check({busy, done, hit, err} == 4'b0, "R7", "reset outputs", {busy, done, hit, err}, 0);
        check(miss_count == 0, "R7", "reset count", miss_count, 0);

        // R7: tag zero hits right after reset.
        send(32'h0000_0004, 4);

        // R1/R2/R3: five tags in set 1 (bits [7:4]=1, tag from bit 8).
        cur_req = "R3";
        for (int t = 1; t <= 4; t++) send((t << 8) | 32'h10, 1);
        cur_req = "R2";
        send((1 << 8) | 32'h10, 2);       // hit in the last slot, moved to front
        cur_req = "R3";
        send((5 << 8) | 32'h10, 1);       // evicts tag 2
        send((2 << 8) | 32'h10, 1);       // miss
        cur_req = "R2";
        send((1 << 8) | 32'h10, 1);       // still resident
        cur_req = "R1";
        send(32'h0000_0110 + 32'h0000_1000, 1);  // different tag, same set

        // R4/R5: two-line references, including wrap from set 15 to set 0.
        cur_req = "R4";
        send(32'h0000_01FE, 4);           // both lines miss, one miss counted
        send(32'h0000_01FE, 4);           // both hit
        send(32'h0000_031C, 8);           // sets 1 and 2, tag 3: set 1 miss
        cur_req = "R5";
        send(32'h0000_052E, 4);           // sets 2,3 tag 5
        send(32'h0000_052E, 4);

        // R6: spans of three or more sets are rejected without state change.
        cur_req = "R6";
        send(32'h0000_0708, 40);          // sets 0..2
        send(32'h0000_0708, 1);           // tag 7 must still miss
        send(32'h0000_0908, 40);
        send(32'h0000_0908, 40);

        // R8: valid held high across a busy window; extra strobes ignored.
        cur_req = "R8";
        req_valid = 1'b1; req_addr = 32'h0000_0A40; req_size = 6'd2;
        for (int k = 0; k < 12; k++) tick();
        req_valid = 1'b0;
        while (m_busy) tick();

        // R9: clear alone, then clear in the same edge as a counted miss.
        cur_req = "R9";
        miss_clr = 1'b1; tick(); miss_clr = 1'b0; tick();
        req_valid = 1'b1; req_addr = 32'h0000_BB00; req_size = 6'd1;
        tick(); req_valid = 1'b0;
        miss_clr = 1'b1; tick(); miss_clr = 1'b0;
        while (m_busy) tick();

        // Random mix of short, two-line and illegal references.
        cur_req = "R4";
        for (int n = 0; n < 600; n++) begin
            int unsigned a;
            int s;
            a = ($urandom_range(0, 7) << 8) | $urandom_range(0, 255);
            s = ($urandom_range(0, 9) == 0) ? $urandom_range(17, 40) : $urandom_range(1, 8);
            send(a, s);
        end

        // R9/R10: direct-mapped instance with a 3-bit counter.
        cur_req = "R10";
        for (int n = 0; n < 9; n++) begin
            s_access((n % 2 == 0) ? 32'h0000_0400 : 32'h0000_0000, sh);
            check(sh == 1'b0, "R10", "direct-mapped alternating miss", sh, 0);
            if (n == 6) check(s_count == 3'd7, "R9", "count reaches top", s_count, 7);
        end
        check(s_count == 3'd7, "R9", "count saturated", s_count, 7);
        s_access(32'h0000_0400, sh);
        check(sh == 1'b1, "R10", "repeat of last tag hits", sh, 1);
        check(s_count == 3'd7, "R9", "count unchanged on hit", s_count, 7);
        s_clr = 1'b1; tick(); s_clr = 1'b0; tick();
        check(s_count == 3'd0, "R9", "clear port", s_count, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule